// File: doc/BRIEF.md
# Periodic Interrupt Timer with Flags

This block produces a periodic timeout from the base clock and collects it, together with three external event sources, into a four-bit interrupt flag register. A companion mask register holds one enable bit per source. It also holds a two-bit prescaler select field that a neighbouring timer reads. Software reaches both registers over a byte-wide bus with a one-bit address. Reads are combinational. Writes take effect at the clock edge.

The timeout runs freely from reset, and each period begins at the previous timeout. Clearing the flag never restarts the count, so the interval between timeouts does not depend on how quickly software services the flag. The single interrupt output is registered. It is high while any flag is set together with its own enable bit.

Top module: `pit_timer`

## Requirements
- R1: After reset, both registers read 0x00, and `irq_o` is low.
- R2: A rate input r (0..3) sets the period to P = 2^(BASE_LOG2 + r) clock cycles, with BASE_LOG2 defaulting to 13. The periodic flag first sets at the P-th rising edge after reset is released.
- R3: Each later timeout comes exactly P cycles after the previous one. A flag clear made in between does not shift it.
- R4: Every timeout sets the periodic flag, flag-register bit 6, whatever the state of its enable bit.
- R5: A one-cycle pulse on `evt_tmr_ovf`, `evt_acc_ovf` or `evt_acc_edge` sets flag bit 7, 5 or 4 respectively.
- R6: Writing 1 to a flag bit position clears that flag, and writing 0 leaves it unchanged. When a set event and a clear fall in the same cycle, the flag ends up set.
- R7: Address 0 selects the mask register, laid out as 7..4 enables and 1..0 prescaler select. Its bits 3:2 always read 0. Address 1 selects the flag register, whose bits 3:0 always read 0.
- R8: Mask bits 7:4 enable the flag bits in the same positions. `irq_o` equals the OR of (flag AND enable) taken one clock earlier.
- R9: Prescaler select bits 1:0 accept writes only at the first PS_WINDOW (default 64) rising edges after reset. Writes at later edges leave them unchanged.
- R10: A flag whose own enable bit is 0 does not raise `irq_o`, even when the other enable bits are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rate_sel | input | 2 | Timeout period select |
| bus_addr | input | 1 | Register select: 0 mask, 1 flags |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| evt_tmr_ovf | input | 1 | Timer overflow event pulse |
| evt_acc_ovf | input | 1 | Accumulator overflow event pulse |
| evt_acc_edge | input | 1 | Accumulator input edge event pulse |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The bench clears the periodic flag in the middle of a period and then checks that the next timeout still comes exactly one period after the previous one. A design that restarted the count on a clear would set the flag late. It drives a set event and a clear of the same bit in one cycle, where a design with the wrong priority would drop the event. It also writes the prescaler field on the last edge inside the window and on the first edge after it, which exposes an off-by-one window. A table pairs each single enable with events on the other sources, to catch a design that lets one enable leak onto a neighbouring flag. The same table confirms that the interrupt lags the flag by one clock.

// File: rtl/pit_pkg.sv
package pit_pkg;
   // source index inside the 4-bit flag / enable vectors (register bits 7:4)
   localparam int SRC_TMR_OVF  = 3;
   localparam int SRC_PERIODIC = 2;
   localparam int SRC_ACC_OVF  = 1;
   localparam int SRC_ACC_EDGE = 0;
   localparam int NUM_SRC      = 4;
   localparam int PS_W         = 2;
   localparam logic ADDR_MASK  = 1'b0;
   localparam logic ADDR_FLAG  = 1'b1;
   typedef logic [NUM_SRC-1:0] src_vec_t;
endpackage

// File: rtl/pit_rate.sv
module pit_rate #(
   parameter int BASE_LOG2 = 13,
   parameter int RATE_W    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [RATE_W-1:0] rate_sel,
   output logic              tick_o
);
   localparam int CNT_W = BASE_LOG2 + (1 << RATE_W) - 1;

   if (BASE_LOG2 < 2) begin : g_bad_base
      $error("pit_rate: BASE_LOG2 must be at least 2");
   end
   if (RATE_W < 1) begin : g_bad_rate
      $error("pit_rate: RATE_W must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] last_cnt;

   assign last_cnt = (CNT_W'(1) << (BASE_LOG2 + int'(rate_sel))) - CNT_W'(1);
   assign tick_o   = (cnt_q >= last_cnt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (tick_o) cnt_q <= '0;
      else             cnt_q <= cnt_q + CNT_W'(1);
   end

   // R3: the count restarts only from a timeout
   assert_restart_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q != '0) |-> (cnt_q == $past(cnt_q) + CNT_W'(1)));
endmodule

// File: rtl/pit_flags.sv
module pit_flags #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] flags_o
);
   if (N < 1) begin : g_bad_n
      $error("pit_flags: N must be at least 1");
   end

   for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        flags_o[i] <= 1'b0;
         else if (set_i[i]) flags_o[i] <= 1'b1;
         else if (clr_i[i]) flags_o[i] <= 1'b0;
      end

      assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
         set_i[i] |=> flags_o[i]);
      assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_i[i] && !set_i[i]) |=> !flags_o[i]);
      assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (!clr_i[i] && !set_i[i]) |=> $stable(flags_o[i]));
   end
endmodule

// File: rtl/pit_ctrl.sv
module pit_ctrl #(
   parameter int N         = 4,
   parameter int PS_W      = 2,
   parameter int PS_WINDOW = 64
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we_i,
   input  logic [N-1:0]    en_wdata,
   input  logic [PS_W-1:0] ps_wdata,
   output logic [N-1:0]    en_o,
   output logic [PS_W-1:0] ps_o
);
   localparam int WC_W = $clog2(PS_WINDOW + 1);

   if (PS_WINDOW < 1) begin : g_bad_win
      $error("pit_ctrl: PS_WINDOW must be at least 1");
   end

   logic [WC_W-1:0] wcnt_q;
   logic            win_open;

   assign win_open = (wcnt_q != WC_W'(PS_WINDOW));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        wcnt_q <= '0;
      else if (win_open) wcnt_q <= wcnt_q + WC_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_o <= '0;
         ps_o <= '0;
      end else if (we_i) begin
         en_o <= en_wdata;
         if (win_open) ps_o <= ps_wdata;
      end
   end

   assert_ps_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !win_open |=> $stable(ps_o));
   assert_en_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !we_i |=> $stable(en_o));
endmodule

// File: rtl/pit_timer.sv
module pit_timer
   import pit_pkg::*;
#(
   parameter int BASE_LOG2 = 13,
   parameter int PS_WINDOW = 64
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] rate_sel,
   input  logic       bus_addr,
   input  logic       bus_we,
   input  logic [7:0] bus_wdata,
   output logic [7:0] bus_rdata,
   input  logic       evt_tmr_ovf,
   input  logic       evt_acc_ovf,
   input  logic       evt_acc_edge,
   output logic       irq_o
);
   logic     tick;
   src_vec_t set_vec, clr_vec, flags, en;
   logic [PS_W-1:0] ps;
   logic     mask_we;

   pit_rate #(.BASE_LOG2(BASE_LOG2), .RATE_W(2)) u_rate (
      .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .tick_o(tick));

   always_comb begin
      set_vec               = '0;
      set_vec[SRC_TMR_OVF]  = evt_tmr_ovf;
      set_vec[SRC_PERIODIC] = tick;
      set_vec[SRC_ACC_OVF]  = evt_acc_ovf;
      set_vec[SRC_ACC_EDGE] = evt_acc_edge;
   end

   assign clr_vec = (bus_we && bus_addr == ADDR_FLAG) ? bus_wdata[7:4] : '0;
   assign mask_we = bus_we && (bus_addr == ADDR_MASK);

   pit_flags #(.N(NUM_SRC)) u_flags (
      .clk(clk), .rst_n(rst_n), .set_i(set_vec), .clr_i(clr_vec), .flags_o(flags));

   pit_ctrl #(.N(NUM_SRC), .PS_W(PS_W), .PS_WINDOW(PS_WINDOW)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .we_i(mask_we),
      .en_wdata(bus_wdata[7:4]), .ps_wdata(bus_wdata[PS_W-1:0]),
      .en_o(en), .ps_o(ps));

   assign bus_rdata = (bus_addr == ADDR_FLAG) ? {flags, 4'b0000}
                                              : {en, 2'b00, ps};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_o <= 1'b0;
      else        irq_o <= |(flags & en);
   end

   assert_periodic_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> flags[SRC_PERIODIC]);
   assert_irq_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (en == '0) |=> !irq_o);
   assert_irq_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (flags == '0) |=> !irq_o);
   assert_rsvd_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rdata[3:2] == 2'b00);
   assert_rsvd_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_we && bus_wdata[3:2] != 2'b00) |=> (bus_rdata[3:2] == 2'b00));
endmodule

// File: tb/tb_pit_timer.sv
module tb_pit_timer;
   localparam int CLK_PERIOD = 10;
   localparam int BASE       = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] rate_sel = 2'd0;
   logic       bus_addr = 1'b1;
   logic       bus_we = 1'b0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       evt_tmr_ovf = 1'b0, evt_acc_ovf = 1'b0, evt_acc_edge = 1'b0;
   logic       irq_o;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   pit_timer #(.BASE_LOG2(BASE), .PS_WINDOW(64)) dut (
      .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .bus_addr(bus_addr),
      .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .evt_tmr_ovf(evt_tmr_ovf), .evt_acc_ovf(evt_acc_ovf),
      .evt_acc_edge(evt_acc_edge), .irq_o(irq_o));

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) begin
      if (!rst_n) cyc <= 0;
      else        cyc <= cyc + 1;
   end

   // {mask enables 7:4, events {tmr_ovf, acc_ovf, acc_edge}, expected irq}
   localparam logic [7:0] VEC [8] = '{
      {4'b1000, 3'b100, 1'b1},
      {4'b1000, 3'b011, 1'b0},
      {4'b0010, 3'b010, 1'b1},
      {4'b0010, 3'b101, 1'b0},
      {4'b0001, 3'b001, 1'b1},
      {4'b0001, 3'b110, 1'b0},
      {4'b0000, 3'b111, 1'b0},
      {4'b1011, 3'b000, 1'b0}};

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   task automatic rd(input logic a, output logic [7:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
      bus_addr = 1'b1;
   endtask

   task automatic do_write(input logic a, input logic [7:0] d);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0; bus_addr = 1'b1; bus_wdata = 8'h00;
   endtask

   task automatic go_edge(input int e);
      while (cyc < e) @(negedge clk);
   endtask

   task automatic do_reset(input logic [1:0] r);
      rst_n = 1'b0;
      rate_sel = r;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] d;
      int t;
      // ---------- phase 1: rate 0, P = 16 ----------
      @(negedge clk);
      do_reset(2'd0);
      rd(1'b1, d); chk("R1 flags after reset", d, 8'h00);
      rd(1'b0, d); chk("R1 mask after reset", d, 8'h00);
      chk("R1 irq after reset", irq_o, 1'b0);

      go_edge(15); rd(1'b1, d); chk("R2 no flag before P", d[6], 1'b0);
      go_edge(16); rd(1'b1, d); chk("R2 flag at edge P", d[6], 1'b1);
      chk("R4 irq stays low with enable off", irq_o, 1'b0);

      do_write(1'b0, 8'h03);
      rd(1'b0, d); chk("R9 prescaler write inside window", d, 8'h03);

      go_edge(70);
      do_write(1'b0, 8'hFC);
      rd(1'b0, d); chk("R9 R7 prescaler locked, reserved read 0", d, 8'hF3);
      do_write(1'b0, 8'h00);
      rd(1'b1, d); chk("R7 flag low nibble reads 0", d[3:0], 4'h0);

      // table walk: R5, R8, R10
      for (int i = 0; i < 8; i++) begin
         do_write(1'b0, {VEC[i][7:4], 4'h0});
         do_write(1'b1, 8'hF0);
         evt_tmr_ovf = VEC[i][3]; evt_acc_ovf = VEC[i][2]; evt_acc_edge = VEC[i][1];
         @(negedge clk);
         evt_tmr_ovf = 1'b0; evt_acc_ovf = 1'b0; evt_acc_edge = 1'b0;
         rd(1'b1, d);
         chk($sformatf("R5 vec %0d flags", i), {d[7], d[5], d[4]}, VEC[i][3:1]);
         chk($sformatf("R8 vec %0d irq latency", i), irq_o, 1'b0);
         @(negedge clk);
         chk($sformatf("R8 R10 vec %0d irq", i), irq_o, VEC[i][0]);
      end

      // periodic flag, irq latency, clear, period independence
      t = (cyc / 16 + 2) * 16;
      go_edge(t - 4);
      do_write(1'b1, 8'hF0);
      do_write(1'b0, 8'h40);
      go_edge(t - 1);
      rd(1'b1, d); chk("R3 flag clear before timeout", d[6], 1'b0);
      chk("R8 irq low before timeout", irq_o, 1'b0);
      go_edge(t);
      rd(1'b1, d); chk("R3 timeout on period grid", d[6], 1'b1);
      chk("R8 irq one cycle after flag", irq_o, 1'b0);
      go_edge(t + 1); chk("R8 irq follows enabled flag", irq_o, 1'b1);
      do_write(1'b1, 8'h40);
      rd(1'b1, d); chk("R6 write 1 clears flag", d[6], 1'b0);
      go_edge(t + 3); chk("R8 irq drops after clear", irq_o, 1'b0);
      go_edge(t + 15); rd(1'b1, d); chk("R3 clear does not restart", d[6], 1'b0);
      go_edge(t + 16); rd(1'b1, d); chk("R3 next timeout from previous", d[6], 1'b1);
      do_write(1'b1, 8'h00);
      rd(1'b1, d); chk("R6 write 0 leaves flag", d[6], 1'b1);

      // set wins over clear
      do_write(1'b1, 8'h80);
      bus_we = 1'b1; bus_addr = 1'b1; bus_wdata = 8'h80; evt_tmr_ovf = 1'b1;
      @(negedge clk);
      bus_we = 1'b0; bus_wdata = 8'h00; evt_tmr_ovf = 1'b0;
      rd(1'b1, d); chk("R6 set wins over clear", d[7], 1'b1);
      do_write(1'b1, 8'h80);
      rd(1'b1, d); chk("R6 clear bit 7", d[7], 1'b0);

      // ---------- phase 2: rate 2, P = 64, window boundary ----------
      do_reset(2'd2);
      go_edge(63);
      rd(1'b1, d); chk("R2 rate 2 no flag at P-1", d[6], 1'b0);
      do_write(1'b0, 8'h01);
      rd(1'b1, d); chk("R2 rate 2 flag at P", d[6], 1'b1);
      rd(1'b0, d); chk("R9 write on last window edge", d[1:0], 2'b01);
      do_write(1'b0, 8'h02);
      rd(1'b0, d); chk("R9 write after window ignored", d[1:0], 2'b01);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule